// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the execute stage of a small 8-bit accumulator processor that uses 12-bit instruction words. Each clock it accepts one instruction word along with the byte already read from the addressed slot of a 32-entry register file and the current accumulator (W) value. It performs the arithmetic, logic, rotate, nibble-exchange, single-bit or literal operation that the word encodes. It returns the result together with one write strobe: either the accumulator strobe or the register-file strobe, with the file address.

The zero (Z), nibble-carry (DC) and carry (C) flags live in a register inside the block. Each opcode refreshes only its own subset of these flags, and every other flag keeps its value. The rotates take their incoming carry from the stored C flag. Subtraction reports C and DC in the "no borrow" sense. All outputs are registered, so the result of an instruction presented before a rising edge is visible just after that edge.

Top module: `acc_alu`

## Requirements
- R1: While reset is high, at the next edge the result, both write strobes, the file address and all three flags become zero.
- R2: For a byte operation, bits [11:6] hold the opcode, bit 5 is the destination flag and bits [4:0] are the file address. A destination flag of 1 raises the file strobe with that address. A destination flag of 0 raises the accumulator strobe. The two strobes are never high together, and outputs appear one cycle after the instruction.
- R3: Opcode 000111 adds W to the file byte modulo 256. C is the carry out of bit 7, DC is the carry out of bit 3, and Z is set when the result is zero.
- R4: Opcode 000010 computes file byte minus W. C is 1 when the file byte is not less than W. DC is 1 when the low nibble of the file byte is not less than the low nibble of W. Z reflects a zero result.
- R5: Opcodes 000101 (AND with W), 000100 (OR with W), 000110 (XOR with W), 000011 (decrement), 001010 (increment, wrapping), 001001 (complement) and 001000 (move file byte) update Z only.
- R6: Opcode 001101 rotates left through carry: bit 7 goes to C and the old C goes to bit 0. Opcode 001100 rotates right through carry: bit 0 goes to C and the old C goes to bit 7. Only C changes.
- R7: Opcode 001110 exchanges the two nibbles. Word 0000001fffff copies W into file address fffff. Neither changes any flag.
- R8: Words with bits [11:8] of 1100, 1101, 1110 and 1111 load the 8-bit literal in bits [7:0] into W, or OR, AND or XOR it with W, and write W. All but 1100 update Z.
- R9: Words with bits [11:8] of 0100 clear, and 0101 set, the bit of the file byte chosen by bits [7:5]. The byte is written back to the file address in bits [4:0], and no flag changes.
- R10: Word 0000011fffff writes zero to file address fffff, and word 000001000000 writes zero to W. Both set Z.
- R11: Any other word raises no strobe, outputs a zero result and address, and leaves all flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| instr_i | input | 12 | Instruction word for this cycle |
| fdata_i | input | 8 | Byte read from the addressed register-file slot |
| wreg_i | input | 8 | Current accumulator value |
| result_o | output | 8 | Registered result (zero when nothing is written) |
| w_we_o | output | 1 | Accumulator write strobe |
| f_we_o | output | 1 | Register-file write strobe |
| f_addr_o | output | 5 | File address to write (zero when no file write) |
| z_o | output | 1 | Zero flag |
| dc_o | output | 1 | Nibble carry / no-nibble-borrow flag |
| c_o | output | 1 | Carry / no-borrow flag |

## Verification
The assertions assume that the file byte and the accumulator value that go with an instruction are stable across the edge that captures it. They also assume that only the carry the block itself stores feeds the rotates, since no carry input exists. The stimulus meets this by changing every input only on the falling edge. It covers hand-picked nibble and byte carry and borrow boundaries, then a long stream of uniformly random 12-bit words, which lands on every defined encoding and many undefined ones. The bench keeps its own flag state through that stream, so a stale or wrongly kept flag shows up on a later rotate or compare.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  typedef enum logic [4:0] {
    OP_NONE, OP_ADD, OP_SUB, OP_AND, OP_IOR, OP_XOR, OP_DEC, OP_INC,
    OP_COM, OP_MOV, OP_RRF, OP_RLF, OP_SWAP, OP_MOVWF, OP_CLR,
    OP_BCLR, OP_BSET, OP_LMOV, OP_LIOR, OP_LAND, OP_LXOR
  } alu_op_e;

  typedef struct packed {
    alu_op_e op;
    logic    wr_w;
    logic    wr_f;
    logic    upd_z;
    logic    upd_dc;
    logic    upd_c;
  } alu_ctl_t;

  // byte-operation opcodes (upper six bits)
  localparam logic [5:0] BOP_MISC0 = 6'b000000;
  localparam logic [5:0] BOP_CLR   = 6'b000001;
  localparam logic [5:0] BOP_SUB   = 6'b000010;
  localparam logic [5:0] BOP_DEC   = 6'b000011;
  localparam logic [5:0] BOP_IOR   = 6'b000100;
  localparam logic [5:0] BOP_AND   = 6'b000101;
  localparam logic [5:0] BOP_XOR   = 6'b000110;
  localparam logic [5:0] BOP_ADD   = 6'b000111;
  localparam logic [5:0] BOP_MOV   = 6'b001000;
  localparam logic [5:0] BOP_COM   = 6'b001001;
  localparam logic [5:0] BOP_INC   = 6'b001010;
  localparam logic [5:0] BOP_RRF   = 6'b001100;
  localparam logic [5:0] BOP_RLF   = 6'b001101;
  localparam logic [5:0] BOP_SWAP  = 6'b001110;

  // literal and bit opcodes (upper four bits)
  localparam logic [3:0] LOP_BCLR = 4'b0100;
  localparam logic [3:0] LOP_BSET = 4'b0101;
  localparam logic [3:0] LOP_MOV  = 4'b1100;
  localparam logic [3:0] LOP_IOR  = 4'b1101;
  localparam logic [3:0] LOP_AND  = 4'b1110;
  localparam logic [3:0] LOP_XOR  = 4'b1111;

endpackage

// File: rtl/acc_alu_decode.sv
module acc_alu_decode
  import acc_alu_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 5,
  parameter int INSTR_W = 12
) (
  input  logic [INSTR_W-1:0] instr_i,
  output alu_ctl_t           ctl_o
);

  localparam int BOP_LSB = ADDR_W + 1;

  logic [INSTR_W-BOP_LSB-1:0] bop;
  logic [INSTR_W-DATA_W-1:0]  lop;
  logic                       dst_file;
  logic                       addr_zero;

  assign bop       = instr_i[INSTR_W-1:BOP_LSB];
  assign lop       = instr_i[INSTR_W-1:DATA_W];
  assign dst_file  = instr_i[ADDR_W];
  assign addr_zero = (instr_i[ADDR_W-1:0] == '0);

  always_comb begin
    ctl_o = '{op: OP_NONE, wr_w: 1'b0, wr_f: 1'b0,
              upd_z: 1'b0, upd_dc: 1'b0, upd_c: 1'b0};
    unique case (lop)
      LOP_MOV: begin ctl_o.op = OP_LMOV; ctl_o.wr_w = 1'b1; end
      LOP_IOR: begin ctl_o.op = OP_LIOR; ctl_o.wr_w = 1'b1; ctl_o.upd_z = 1'b1; end
      LOP_AND: begin ctl_o.op = OP_LAND; ctl_o.wr_w = 1'b1; ctl_o.upd_z = 1'b1; end
      LOP_XOR: begin ctl_o.op = OP_LXOR; ctl_o.wr_w = 1'b1; ctl_o.upd_z = 1'b1; end
      LOP_BCLR: begin ctl_o.op = OP_BCLR; ctl_o.wr_f = 1'b1; end
      LOP_BSET: begin ctl_o.op = OP_BSET; ctl_o.wr_f = 1'b1; end
      4'b0000, 4'b0001, 4'b0010, 4'b0011: begin
        // routed byte operations share the destination rule
        ctl_o.wr_f = dst_file;
        ctl_o.wr_w = !dst_file;
        case (bop)
          BOP_ADD:  begin ctl_o.op = OP_ADD; ctl_o.upd_z = 1'b1;
                          ctl_o.upd_dc = 1'b1; ctl_o.upd_c = 1'b1; end
          BOP_SUB:  begin ctl_o.op = OP_SUB; ctl_o.upd_z = 1'b1;
                          ctl_o.upd_dc = 1'b1; ctl_o.upd_c = 1'b1; end
          BOP_AND:  begin ctl_o.op = OP_AND; ctl_o.upd_z = 1'b1; end
          BOP_IOR:  begin ctl_o.op = OP_IOR; ctl_o.upd_z = 1'b1; end
          BOP_XOR:  begin ctl_o.op = OP_XOR; ctl_o.upd_z = 1'b1; end
          BOP_DEC:  begin ctl_o.op = OP_DEC; ctl_o.upd_z = 1'b1; end
          BOP_INC:  begin ctl_o.op = OP_INC; ctl_o.upd_z = 1'b1; end
          BOP_COM:  begin ctl_o.op = OP_COM; ctl_o.upd_z = 1'b1; end
          BOP_MOV:  begin ctl_o.op = OP_MOV; ctl_o.upd_z = 1'b1; end
          BOP_RRF:  begin ctl_o.op = OP_RRF; ctl_o.upd_c = 1'b1; end
          BOP_RLF:  begin ctl_o.op = OP_RLF; ctl_o.upd_c = 1'b1; end
          BOP_SWAP: begin ctl_o.op = OP_SWAP; end
          BOP_MISC0: begin
            ctl_o.wr_w = 1'b0;
            ctl_o.wr_f = dst_file;
            ctl_o.op   = dst_file ? OP_MOVWF : OP_NONE;
          end
          BOP_CLR: begin
            if (dst_file || addr_zero) begin
              ctl_o.op    = OP_CLR;
              ctl_o.upd_z = 1'b1;
            end else begin
              ctl_o.wr_w = 1'b0;
            end
          end
          default: begin
            ctl_o.wr_w = 1'b0;
            ctl_o.wr_f = 1'b0;
          end
        endcase
      end
      default: ctl_o.op = OP_NONE;
    endcase
  end

endmodule

// File: rtl/acc_alu_exec.sv
module acc_alu_exec
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int BIT_W  = 3
) (
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] fdata_i,
  input  logic [DATA_W-1:0] wreg_i,
  input  logic [DATA_W-1:0] lit_i,
  input  logic [BIT_W-1:0]  bitsel_i,
  input  logic              c_in,
  output logic [DATA_W-1:0] res_o,
  output logic              z_o,
  output logic              dc_o,
  output logic              c_o
);

  localparam int NIB = DATA_W / 2;

  logic [DATA_W:0]   add_w, sub_w;
  logic [NIB:0]      add_n, sub_n;
  logic [DATA_W-1:0] bit_mask;

  assign add_w    = {1'b0, fdata_i} + {1'b0, wreg_i};
  assign sub_w    = {1'b0, fdata_i} - {1'b0, wreg_i};
  assign add_n    = {1'b0, fdata_i[NIB-1:0]} + {1'b0, wreg_i[NIB-1:0]};
  assign sub_n    = {1'b0, fdata_i[NIB-1:0]} - {1'b0, wreg_i[NIB-1:0]};
  assign bit_mask = {{(DATA_W-1){1'b0}}, 1'b1} << bitsel_i;

  always_comb begin
    res_o = fdata_i;
    dc_o  = 1'b0;
    c_o   = c_in;
    unique case (op_i)
      OP_ADD:  begin res_o = add_w[DATA_W-1:0]; c_o = add_w[DATA_W]; dc_o = add_n[NIB]; end
      OP_SUB:  begin res_o = sub_w[DATA_W-1:0]; c_o = !sub_w[DATA_W]; dc_o = !sub_n[NIB]; end
      OP_AND:  res_o = fdata_i & wreg_i;
      OP_IOR:  res_o = fdata_i | wreg_i;
      OP_XOR:  res_o = fdata_i ^ wreg_i;
      OP_DEC:  res_o = fdata_i - 1'b1;
      OP_INC:  res_o = fdata_i + 1'b1;
      OP_COM:  res_o = ~fdata_i;
      OP_MOV:  res_o = fdata_i;
      OP_RRF:  begin res_o = {c_in, fdata_i[DATA_W-1:1]}; c_o = fdata_i[0]; end
      OP_RLF:  begin res_o = {fdata_i[DATA_W-2:0], c_in}; c_o = fdata_i[DATA_W-1]; end
      OP_SWAP: res_o = {fdata_i[NIB-1:0], fdata_i[DATA_W-1:NIB]};
      OP_MOVWF: res_o = wreg_i;
      OP_CLR:  res_o = '0;
      OP_BCLR: res_o = fdata_i & ~bit_mask;
      OP_BSET: res_o = fdata_i | bit_mask;
      OP_LMOV: res_o = lit_i;
      OP_LIOR: res_o = wreg_i | lit_i;
      OP_LAND: res_o = wreg_i & lit_i;
      OP_LXOR: res_o = wreg_i ^ lit_i;
      default: res_o = '0;
    endcase
  end

  assign z_o = (res_o == '0);

endmodule

// File: rtl/acc_alu_flags.sv
module acc_alu_flags (
  input  logic clk_i,
  input  logic rst_i,
  input  logic upd_z_i,
  input  logic upd_dc_i,
  input  logic upd_c_i,
  input  logic z_i,
  input  logic dc_i,
  input  logic c_i,
  output logic z_q,
  output logic dc_q,
  output logic c_q
);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      z_q  <= 1'b0;
      dc_q <= 1'b0;
      c_q  <= 1'b0;
    end else begin
      if (upd_z_i)  z_q  <= z_i;
      if (upd_dc_i) dc_q <= dc_i;
      if (upd_c_i)  c_q  <= c_i;
    end
  end

  // R11
  keep_flags_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !(upd_z_i || upd_dc_i || upd_c_i) |=> $stable({z_q, dc_q, c_q}));

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 5,
  parameter int INSTR_W = 12
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [DATA_W-1:0]  fdata_i,
  input  logic [DATA_W-1:0]  wreg_i,
  output logic [DATA_W-1:0]  result_o,
  output logic               w_we_o,
  output logic               f_we_o,
  output logic [ADDR_W-1:0]  f_addr_o,
  output logic               z_o,
  output logic               dc_o,
  output logic               c_o
);

  localparam int BIT_W = $clog2(DATA_W);

  alu_ctl_t          ctl;
  logic [DATA_W-1:0] res;
  logic              z_n, dc_n, c_n;

  acc_alu_decode #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .INSTR_W(INSTR_W)) u_dec (
    .instr_i (instr_i),
    .ctl_o   (ctl)
  );

  acc_alu_exec #(.DATA_W(DATA_W), .BIT_W(BIT_W)) u_exec (
    .op_i     (ctl.op),
    .fdata_i  (fdata_i),
    .wreg_i   (wreg_i),
    .lit_i    (instr_i[DATA_W-1:0]),
    .bitsel_i (instr_i[ADDR_W+BIT_W-1:ADDR_W]),
    .c_in     (c_o),
    .res_o    (res),
    .z_o      (z_n),
    .dc_o     (dc_n),
    .c_o      (c_n)
  );

  acc_alu_flags u_flags (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .upd_z_i  (ctl.upd_z),
    .upd_dc_i (ctl.upd_dc),
    .upd_c_i  (ctl.upd_c),
    .z_i      (z_n),
    .dc_i     (dc_n),
    .c_i      (c_n),
    .z_q      (z_o),
    .dc_q     (dc_o),
    .c_q      (c_o)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      result_o <= '0;
      w_we_o   <= 1'b0;
      f_we_o   <= 1'b0;
      f_addr_o <= '0;
    end else begin
      result_o <= (ctl.wr_w || ctl.wr_f) ? res : '0;
      w_we_o   <= ctl.wr_w;
      f_we_o   <= ctl.wr_f;
      f_addr_o <= ctl.wr_f ? instr_i[ADDR_W-1:0] : '0;
    end
  end

  // R1
  rst_quiet_chk: assert property (@(posedge clk_i)
    rst_i |=> (!w_we_o && !f_we_o && !z_o && !dc_o && !c_o));

  // R2
  one_strobe_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !(w_we_o && f_we_o));

  // R4
  sub_noborrow_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (ctl.op == OP_SUB) |=> (c_o == ($past(fdata_i) >= $past(wreg_i))));

  // R6
  rlf_carry_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (ctl.op == OP_RLF) |=> (c_o == $past(fdata_i[DATA_W-1])));

  // R7
  swap_flags_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (ctl.op == OP_SWAP || ctl.op == OP_MOVWF) |=> $stable({z_o, dc_o, c_o}));

  // R8
  lit_dest_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (instr_i[INSTR_W-1:INSTR_W-2] == 2'b11) |=> (w_we_o && !f_we_o));

  // R10
  clr_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (ctl.op == OP_CLR) |=> (result_o == '0 && z_o));

endmodule

// File: tb/acc_alu_test.sv
module acc_alu_test;

  logic        clk = 1'b0;
  logic        rst;
  logic [11:0] instr;
  logic [7:0]  fdata, wreg;
  logic [7:0]  result;
  logic        w_we, f_we, z, dc, c;
  logic [4:0]  f_addr;

  int checks = 0;
  int fails  = 0;

  // reference flag state
  int mz = 0, mdc = 0, mc = 0;

  always #2 clk = ~clk;

  acc_alu uut (
    .clk_i(clk), .rst_i(rst), .instr_i(instr), .fdata_i(fdata), .wreg_i(wreg),
    .result_o(result), .w_we_o(w_we), .f_we_o(f_we), .f_addr_o(f_addr),
    .z_o(z), .dc_o(dc), .c_o(c)
  );

  function automatic logic [17:0] pack(int r, int ww, int wf, int a, int fz, int fdc, int fc);
    logic [17:0] v;
    v = {r[7:0], ww[0], wf[0], a[4:0], fz[0], fdc[0], fc[0]};
    return v;
  endfunction

  task automatic compare(input logic [17:0] exp, input string tag);
    logic [17:0] act;
    act = {result, w_we, f_we, f_addr, z, dc, c};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h {res,ww,wf,addr,z,dc,c}", tag, act, exp);
    end
  endtask

  // Applies one instruction at a falling edge, predicts, checks after the next rising edge.
  task automatic step(input logic [11:0] ins, input int f, input int w);
    int op6, op4, d, k, b, er, ew, ef, s;
    string tag;
    instr = ins; fdata = f[7:0]; wreg = w[7:0];
    op6 = int'(ins[11:6]); op4 = int'(ins[11:8]); d = int'(ins[5]);
    k = int'(ins[7:0]); b = int'(ins[7:5]);
    er = 0; ew = 0; ef = 0; tag = "R11";
    case (op4)
      12: begin er = k; ew = 1; tag = "R8"; end
      13: begin er = w | k; ew = 1; mz = (er == 0); tag = "R8"; end
      14: begin er = w & k; ew = 1; mz = (er == 0); tag = "R8"; end
      15: begin er = (w ^ k) & 255; ew = 1; mz = (er == 0); tag = "R8"; end
      4:  begin er = f & ~(1 << b) & 255; ef = 1; tag = "R9"; end
      5:  begin er = (f | (1 << b)) & 255; ef = 1; tag = "R9"; end
      0, 1, 2, 3: begin
        case (op6)
          0: if (d == 1) begin er = w; ef = 1; tag = "R7"; end
          1: if (d == 1) begin er = 0; ef = 1; mz = 1; tag = "R10"; end
             else if (ins[4:0] == 5'd0) begin er = 0; ew = 1; mz = 1; tag = "R10"; end
          2: begin s = f - w; er = s & 255; mc = (f >= w); mdc = ((f & 15) >= (w & 15));
                   mz = (er == 0); tag = "R4 R2"; end
          7: begin s = f + w; er = s & 255; mc = (s > 255); mdc = ((f & 15) + (w & 15) > 15);
                   mz = (er == 0); tag = "R3 R2"; end
          3, 4, 5, 6, 8, 9, 10: begin
            case (op6)
              3:  er = (f + 255) & 255;
              4:  er = f | w;
              5:  er = f & w;
              6:  er = f ^ w;
              8:  er = f;
              9:  er = (~f) & 255;
              default: er = (f + 1) & 255;
            endcase
            mz = (er == 0); tag = "R5 R2";
          end
          12: begin er = (mc << 7) | (f >> 1); mc = f & 1; tag = "R6 R2"; end
          13: begin er = ((f << 1) & 255) | mc; mc = (f >> 7) & 1; tag = "R6 R2"; end
          14: begin er = ((f & 15) << 4) | (f >> 4); tag = "R7 R2"; end
          default: ;
        endcase
        if (op6 >= 2 && op6 <= 14 && op6 != 11) begin
          ef = d; ew = 1 - d;
        end
      end
      default: ;
    endcase
    @(posedge clk);
    @(negedge clk);
    compare(pack(er, ew, ef, ef ? int'(ins[4:0]) : 0, mz, mdc, mc), tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; instr = 12'h000; fdata = 8'h00; wreg = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare(pack(0, 0, 0, 0, 0, 0, 0), "R1 reset state");
    rst = 1'b0;

    // R3 add: nibble carry only, then byte carry with zero
    step(12'b000111_1_00110, 8'h0F, 8'h01);
    step(12'b000111_0_00110, 8'h80, 8'h80);
    step(12'b000111_1_11111, 8'hF0, 8'h0F);
    // R4 subtract: equal, borrow, nibble borrow
    step(12'b000010_0_00001, 8'h05, 8'h05);
    step(12'b000010_1_00010, 8'h03, 8'h05);
    step(12'b000010_1_00011, 8'h10, 8'h01);
    // R6 rotates through carry
    step(12'b001101_1_00100, 8'h81, 8'h00);
    step(12'b001101_0_00100, 8'h40, 8'h00);
    step(12'b001100_1_00100, 8'h01, 8'h00);
    step(12'b001100_0_00100, 8'h02, 8'h00);
    // R7 swap and copy-from-W leave flags alone
    step(12'b001110_0_00101, 8'hA5, 8'h00);
    step(12'b000000_1_01010, 8'h00, 8'h3C);
    // R5 single-flag operations
    step(12'b001010_1_00111, 8'hFF, 8'h00);
    step(12'b000011_0_00111, 8'h01, 8'h00);
    step(12'b001001_1_00111, 8'hFF, 8'h00);
    step(12'b000101_0_00111, 8'hF0, 8'h0F);
    step(12'b000100_1_00111, 8'h00, 8'h00);
    step(12'b000110_0_00111, 8'h5A, 8'h5A);
    step(12'b001000_0_00111, 8'h7E, 8'h00);
    // R8 literals: MOVLW 0 must not touch Z
    step(12'hC00, 8'h00, 8'h11);
    step(12'hDF0, 8'h00, 8'h0F);
    step(12'hE0F, 8'h00, 8'hF0);
    step(12'hFAA, 8'h00, 8'hAA);
    // R9 bit clear / set
    step(12'b0100_111_00110, 8'hFF, 8'h00);
    step(12'b0101_000_01001, 8'h00, 8'h00);
    // R10 clears
    step(12'b0000011_10001, 8'h55, 8'h55);
    step(12'h040, 8'h55, 8'h55);
    // R11 undefined words
    step(12'h000, 8'h12, 8'h34);
    step(12'hA05, 8'h00, 8'h00);
    step(12'h042, 8'h00, 8'h00);
    step(12'b001111_1_00001, 8'hFF, 8'h00);

    for (int i = 0; i < 4000; i++) begin
      step(12'($urandom), int'($urandom_range(0, 255)), int'($urandom_range(0, 255)));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule